// File: doc/BRIEF.md
# UART Serial Transmitter with Holding Register

This block is the transmit half of an asynchronous serial port. A byte written into a one-entry holding register waits there until the shift register is free. It then moves across and goes out on a single serial line as one framed character. The line advances by one bit on each pulse of an externally supplied baud-rate tick, so the block itself contains no rate divider. Because the holding register and the shift register are separate, software or a bus agent can queue the next byte while the current one is still shifting out, and consecutive characters leave with no idle time between them.

Three control strobes set the operating state. Enable arms the transmitter. Disable lets the byte that is shifting and the byte that is held both finish before the transmitter turns off. Reset drops everything at once. A three-bit mode input chooses the parity bit, and two flags report whether the holding register can take a byte and whether the whole path has drained.

Top module: `uart_tx_core`

## Requirements
- R1: After `rstN` is released the transmitter is disabled: `txLine` = 1, `holdReady` = 0, `txEmpty` = 1. No byte written while it is disabled is ever sent.
- R2: An enable strobe on an idle transmitter raises `holdReady` in the next cycle. The line stays at 1 until a byte is written.
- R3: A frame has a start bit of 0, then DATA_W data bits with the least significant bit first, then the parity bit when one is selected, then one stop bit of 1. A frame starts at a baud tick, and each bit holds for one tick interval.
- R4: `parMode` encoding: 0 = even parity (the data plus the parity bit hold an even number of ones), 1 = odd parity, 2 = parity bit forced to 0, 3 = parity bit forced to 1, 4 to 7 = no parity bit.
- R5: `parMode` is captured when a byte moves into the shift register. A change made later does not alter that frame.
- R6: A held byte moves into the shift register on the tick that ends the current stop bit, so its start bit follows with no idle tick. `holdReady` is low while a byte is held.
- R7: A write is ignored when `holdReady` is low, and also when a disable or reset strobe arrives in the same cycle.
- R8: `txEmpty` is 1 exactly when no byte is held and no frame is in progress, including its stop bit.
- R9: A disable strobe lowers `holdReady` in the next cycle. If a byte is shifting or held, both bytes are still sent and the transmitter then stops. Writes made after the disable are ignored.
- R10: A reset strobe aborts at once. In the next cycle `txLine` = 1, `txEmpty` = 1 and `holdReady` = 0, and any held byte is discarded.
- R11: Strobe priority is reset over disable over enable when they arrive in the same cycle.
- R12: `txLine` changes only at a clock edge that carries a baud tick or a reset strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse per bit period |
| enStb | input | 1 | Enable strobe |
| disStb | input | 1 | Graceful disable strobe |
| rstStb | input | 1 | Immediate transmitter reset strobe |
| parMode | input | 3 | Parity selection, encoded as in R4 |
| wrStb | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_W | Byte to queue |
| txLine | output | 1 | Serial output, idle high |
| holdReady | output | 1 | Holding register can accept a byte |
| txEmpty | output | 1 | Holding and shift registers both empty |

## Verification
The bench uses the default DATA_W of 8 and drives a baud tick every fourth clock. With frames of 40 to 44 cycles, every parity mode, a back-to-back pair, a drain, and an abort partway through a frame all fit in a short run. A scoreboard decodes each frame from the line one tick at a time and compares it against the queue of written bytes. A recorded start-tick log measures the gap between consecutive frames. Strobes are placed at chosen points inside frames to exercise the drain, abort and priority cases.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam logic [1:0] PAR_EVEN  = 2'd0;
  localparam logic [1:0] PAR_ODD   = 2'd1;
  localparam logic [1:0] PAR_SPACE = 2'd2;
  localparam logic [1:0] PAR_MARK  = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic flush;     // drop everything, line back to idle
    logic acceptWr;  // capture wrData into the holding register
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_DRAIN = 2'd2
  } txState_e;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enStb,
  input  logic      disStb,
  input  logic      rstStb,
  input  logic      wrStb,
  input  logic      holdValid,
  input  logic      busy,
  output txStrobe_t strb,
  output logic      holdReady
);

  txState_e state, stateNext;
  logic pathIdle;

  assign pathIdle  = !holdValid && !busy;
  assign holdReady = (state == ST_ON) && !holdValid;

  always_comb begin
    strb.flush    = rstStb;
    strb.acceptWr = wrStb && holdReady && !disStb && !rstStb;
  end

  always_comb begin
    stateNext = state;
    if (rstStb) begin
      stateNext = ST_OFF;
    end else if (disStb) begin
      if (state == ST_OFF || pathIdle) stateNext = ST_OFF;
      else                             stateNext = ST_DRAIN;
    end else if (enStb) begin
      stateNext = ST_ON;
    end else if (state == ST_DRAIN && pathIdle) begin
      stateNext = ST_OFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        parMode,
  output logic              holdValid,
  output logic              busy,
  output logic              txLine
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_PAR  = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_NONE = CNT_W'(DATA_W + 1);

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   lastIdx;

  logic               atLast, loadNow, frameDone, parBit;
  logic [FRAME_W-1:0] frameNew;
  logic [CNT_W-1:0]   lastNew;

  assign atLast    = busy && (bitCnt == lastIdx);
  assign loadNow   = baudTick && holdValid && (!busy || atLast);
  assign frameDone = baudTick && atLast;

  always_comb begin
    case (parMode[1:0])
      PAR_EVEN:  parBit = ^holdReg;
      PAR_ODD:   parBit = ~^holdReg;
      PAR_SPACE: parBit = 1'b0;
      default:   parBit = 1'b1;
    endcase
    if (parMode[2]) begin
      frameNew = {2'b11, holdReg, 1'b0};
      lastNew  = LAST_NONE;
    end else begin
      frameNew = {1'b1, parBit, holdReg, 1'b0};
      lastNew  = LAST_PAR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
      shiftReg  <= '1;
      bitCnt    <= '0;
      lastIdx   <= LAST_NONE;
      busy      <= 1'b0;
    end else if (strb.flush) begin
      holdValid <= 1'b0;
      shiftReg  <= '1;
      bitCnt    <= '0;
      busy      <= 1'b0;
    end else begin
      if (loadNow) begin
        shiftReg  <= frameNew;
        lastIdx   <= lastNew;
        bitCnt    <= '0;
        busy      <= 1'b1;
        holdValid <= 1'b0;
      end else if (frameDone) begin
        busy <= 1'b0;
      end else if (busy && baudTick) begin
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (strb.acceptWr) begin
        holdReg   <= wrData;
        holdValid <= 1'b1;
      end
    end
  end

  assign txLine = busy ? shiftReg[0] : 1'b1;

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              enStb,
  input  logic              disStb,
  input  logic              rstStb,
  input  logic [2:0]        parMode,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine,
  output logic              holdReady,
  output logic              txEmpty
);

  txStrobe_t strb;
  logic      holdValid, busy;

  uart_tx_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enStb     (enStb),
    .disStb    (disStb),
    .rstStb    (rstStb),
    .wrStb     (wrStb),
    .holdValid (holdValid),
    .busy      (busy),
    .strb      (strb),
    .holdReady (holdReady)
  );

  uart_tx_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .strb      (strb),
    .wrData    (wrData),
    .parMode   (parMode),
    .holdValid (holdValid),
    .busy      (busy),
    .txLine    (txLine)
  );

  assign txEmpty = !holdValid && !busy;

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic enStb,
  input logic disStb,
  input logic rstStb,
  input logic wrStb,
  input logic txLine,
  input logic holdReady,
  input logic txEmpty
);

  p_line_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!baudTick && !rstStb) |=> $stable(txLine));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    rstStb |=> (txLine && txEmpty && !holdReady));

  p_disable_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    disStb |=> !holdReady);

  p_write_fills_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && holdReady && !disStb && !rstStb) |=> (!holdReady && !txEmpty));

  p_enable_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enStb && !disStb && !rstStb && txEmpty) |=> holdReady);

  p_empty_line_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txLine);

  p_reset_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enStb && rstStb) |=> !holdReady);

endmodule

bind uart_tx_core uart_tx_core_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .baudTick  (baudTick),
  .enStb     (enStb),
  .disStb    (disStb),
  .rstStb    (rstStb),
  .wrStb     (wrStb),
  .txLine    (txLine),
  .holdReady (holdReady),
  .txEmpty   (txEmpty)
);

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;

  localparam int DATA_W   = 8;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic enStb = 1'b0, disStb = 1'b0, rstStb = 1'b0, wrStb = 1'b0;
  logic [2:0] parMode = 3'd4;
  logic [DATA_W-1:0] wrData = '0;
  logic txLine, holdReady, txEmpty;

  always #4 clk = ~clk;

  uart_tx_core #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .enStb(enStb),
    .disStb(disStb), .rstStb(rstStb), .parMode(parMode), .wrStb(wrStb),
    .wrData(wrData), .txLine(txLine), .holdReady(holdReady), .txEmpty(txEmpty)
  );

  typedef struct {
    logic [DATA_W-1:0] data;
    logic [2:0]        mode;
  } item_t;

  item_t expQ[$];
  int    startLog[$];
  int    errors = 0, checks = 0;
  int    frameCount = 0, tickNum = 0, divCnt = 0, cycles = 0;
  int    bitPos = -1;
  bit    monAbort = 1'b0;
  item_t cur;
  logic [DATA_W-1:0] got;
  logic parGot;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic expParity(input item_t it);
    case (it.mode[1:0])
      2'd0:    return ^it.data;
      2'd1:    return ~^it.data;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // Monitor: one sample per baud tick, decoded and compared to the queue
  task automatic sampleLine();
    bit hasPar;
    int stopPos;
    if (bitPos < 0) begin
      if (txLine == 1'b0) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R7", "unexpected frame start", 0, 1);
          cur.data = '0;
          cur.mode = 3'd4;
        end else begin
          cur = expQ[0];
        end
        bitPos = 0;
        got = '0;
        startLog.push_back(tickNum);
      end
    end else begin
      hasPar  = !cur.mode[2];
      stopPos = hasPar ? DATA_W + 2 : DATA_W + 1;
      bitPos++;
      if (bitPos <= DATA_W) begin
        got[bitPos-1] = txLine;
      end else if (hasPar && bitPos == DATA_W + 1) begin
        parGot = txLine;
      end
      if (bitPos == stopPos) begin
        chk(txLine == 1'b1, "R3", "stop bit", int'(txLine), 1);
        chk(got == cur.data, "R3", "data bits", int'(got), int'(cur.data));
        if (hasPar)
          chk(parGot == expParity(cur), "R4", "parity bit", int'(parGot),
              int'(expParity(cur)));
        if (expQ.size() != 0) void'(expQ.pop_front());
        frameCount++;
        bitPos = -1;
      end
    end
  endtask

  always @(negedge clk) begin
    if (monAbort) bitPos = -1;
    if (rstN && baudTick) begin
      tickNum++;
      sampleLine();
    end
    divCnt   = (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    baudTick = rstN && (divCnt == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Driver: waits for room, writes, records the expected frame
  task automatic sendByte(input logic [DATA_W-1:0] d, input logic [2:0] m);
    item_t it;
    while (!holdReady) @(negedge clk);
    parMode = m;
    wrData  = d;
    wrStb   = 1'b1;
    it.data = d;
    it.mode = m;
    expQ.push_back(it);
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic pulseWrite(input logic [DATA_W-1:0] d);
    wrData = d;
    wrStb  = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic strobe(input bit e, input bit d, input bit r);
    enStb = e; disStb = d; rstStb = r;
    @(negedge clk);
    enStb = 1'b0; disStb = 1'b0; rstStb = 1'b0;
  endtask

  task automatic waitTicks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0 || bitPos >= 0 || !txEmpty) @(negedge clk);
    waitTicks(2);
  endtask

  initial begin
    int fc;
    logic [DATA_W-1:0] pat [5];
    pat[0] = 8'h5A; pat[1] = 8'h37; pat[2] = 8'hFE; pat[3] = 8'h00; pat[4] = 8'h81;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(txLine == 1'b1, "R1", "line after reset", int'(txLine), 1);
    chk(holdReady == 1'b0, "R1", "ready after reset", int'(holdReady), 0);
    chk(txEmpty == 1'b1, "R1", "empty after reset", int'(txEmpty), 1);
    pulseWrite(8'hA5);
    waitTicks(15);
    chk(frameCount == 0, "R1", "frames while disabled", frameCount, 0);
    chk(txEmpty == 1'b1, "R1", "empty while disabled", int'(txEmpty), 1);

    // R2: enable, idle high
    strobe(1, 0, 0);
    chk(holdReady == 1'b1, "R2", "ready after enable", int'(holdReady), 1);
    waitTicks(5);
    chk(txLine == 1'b1 && frameCount == 0, "R2", "idle line after enable",
        int'(txLine), 1);

    // R3, R4: every parity mode
    for (int m = 0; m < 5; m++) begin
      sendByte(pat[m], 3'(m));
      waitDrain();
    end
    sendByte(8'h6C, 3'd7);
    waitDrain();
    chk(frameCount == 6, "R4", "frames over all modes", frameCount, 6);

    // R5: mode captured at load
    sendByte(8'h01, 3'd0);
    while (txLine) @(negedge clk);
    parMode = 3'd1;
    waitDrain();
    chk(frameCount == 7, "R5", "frame with changed mode", frameCount, 7);

    // R6, R7, R8: back-to-back pair, ignored write
    fc = frameCount;
    sendByte(8'hC3, 3'd0);
    sendByte(8'h3C, 3'd0);
    chk(holdReady == 1'b0, "R6", "ready low while held", int'(holdReady), 0);
    chk(txEmpty == 1'b0, "R8", "empty low while busy", int'(txEmpty), 1'b0);
    pulseWrite(8'hFF);
    waitDrain();
    chk(frameCount == fc + 2, "R7", "frames after ignored write", frameCount, fc + 2);
    chk(startLog[startLog.size()-1] - startLog[startLog.size()-2] == DATA_W + 3,
        "R6", "ticks between starts",
        startLog[startLog.size()-1] - startLog[startLog.size()-2], DATA_W + 3);
    chk(txEmpty == 1'b1, "R8", "empty after drain", int'(txEmpty), 1);

    // R9: graceful disable drains both bytes
    fc = frameCount;
    sendByte(8'h11, 3'd3);
    sendByte(8'h22, 3'd2);
    strobe(0, 1, 0);
    chk(holdReady == 1'b0, "R9", "ready after disable", int'(holdReady), 0);
    waitDrain();
    chk(frameCount == fc + 2, "R9", "frames drained", frameCount, fc + 2);
    chk(holdReady == 1'b0 && txEmpty == 1'b1, "R9", "stopped after drain",
        int'(holdReady), 0);
    pulseWrite(8'h77);
    waitTicks(15);
    chk(frameCount == fc + 2, "R9", "write after disable", frameCount, fc + 2);

    // R9: immediate disable when idle
    strobe(1, 0, 0);
    chk(holdReady == 1'b1, "R9", "re-enabled", int'(holdReady), 1);
    strobe(0, 1, 0);
    chk(holdReady == 1'b0, "R9", "idle disable", int'(holdReady), 0);

    // R11: priority
    strobe(1, 1, 0);
    chk(holdReady == 1'b0, "R11", "enable+disable while off", int'(holdReady), 0);
    strobe(1, 0, 1);
    chk(holdReady == 1'b0, "R11", "enable+reset", int'(holdReady), 0);
    strobe(1, 0, 0);
    strobe(1, 1, 0);
    chk(holdReady == 1'b0, "R11", "enable+disable while on", int'(holdReady), 0);
    strobe(1, 0, 0);
    chk(holdReady == 1'b1, "R11", "enable alone", int'(holdReady), 1);

    // R10: abort partway through a frame
    fc = frameCount;
    sendByte(8'hE7, 3'd1);
    sendByte(8'h18, 3'd0);
    while (txLine) @(negedge clk);
    waitTicks(3);
    monAbort = 1'b1;
    rstStb   = 1'b1;
    @(negedge clk);
    rstStb = 1'b0;
    chk(txLine == 1'b1, "R10", "line after abort", int'(txLine), 1);
    chk(txEmpty == 1'b1, "R10", "empty after abort", int'(txEmpty), 1);
    chk(holdReady == 1'b0, "R10", "ready after abort", int'(holdReady), 0);
    expQ.delete();
    @(negedge clk);
    monAbort = 1'b0;
    waitTicks(15);
    chk(frameCount == fc && txLine == 1'b1, "R10", "held byte discarded",
        frameCount, fc);

    // R2, R3: recovery after abort
    strobe(1, 0, 0);
    sendByte(8'h96, 3'd4);
    waitDrain();
    chk(frameCount == fc + 1, "R3", "frame after recovery", frameCount, fc + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule